// File: doc/BRIEF.md
# Fixed-Priority PCI Bus Arbiter

This block is the central bus arbiter of a conventional parallel PCI segment. Six external masters and the host bridge compete for the bus. The six external masters request on active-low lines and receive active-low grants. The host bridge uses an internal active-high pair. The arbiter registers every request, picks a winner through a tree of two-input selectors, and drives at most one grant at a time. Grants change only when the bus is idle.

The arbiter watches FRAME# and IRDY# to detect an idle bus and to count completed transactions under the current grant. A 32-bit control word sets two things: where the idle bus parks, and how many back-to-back transactions a master may run while a lower-priority agent waits. A strap sampled during reset switches the whole arbiter off.

Agents are numbered 0 to 6. External master i uses `req_n[i]` and `gnt_n[i]`. Agent 6 is the host bridge (`host_req`, `host_gnt`).

Top module: `pci_prio_arbiter`

## Requirements
- R1: At most one of the seven grants (six `gnt_n` lines low plus `host_gnt` high) is asserted in any cycle.
- R2: When several agents request at once, the lowest agent number wins. External master 0 ranks highest. The host bridge (agent 6) ranks below every external master.
- R3: A master keeps its grant while it keeps requesting. A higher-priority request that arrives later does not take the bus away from it, unless the limit of R4 fires.
- R4: The limit is control bits [31:28] and is called N. When N is not 0, the master's grant is removed after it completes N transactions under one grant while some agent numbered above it is requesting. The next grant then goes to another requesting agent.
- R5: The limit has no effect in two cases: when no agent numbered above the owner is requesting, or when the field is 0. In both cases the master keeps its grant for any number of transactions.
- R6: With control bit 27 at 0 and no request pending, the bus parks on the host bridge.
- R7: With control bit 27 at 1 and no request pending, the bus parks on the agent that held the grant last.
- R8: The control word resets to 0. Bits [31:27] are writable. Bits [26:0] always read 0, whatever was written.
- R9: If `strap_en` is low while reset is asserted, no grant is asserted at any time until the next reset.
- R10: A new grant is issued only after the bus has been sampled idle (FRAME# and IRDY# both high). Between grants to two different agents there is at least one cycle with no grant.
- R11: A transaction counts as complete only when IRDY# is seen low with FRAME# high and then high in the next cycle. An address phase without IRDY# does not count. The per-grant count clears when the grant moves to a different agent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| strap_en | input | 1 | Arbiter enable, captured while reset is asserted |
| req_n | input | 6 | Active-low requests of external masters 0..5 |
| host_req | input | 1 | Host bridge request, active high |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| gnt_n | output | 6 | Active-low grants to external masters 0..5 |
| host_gnt | output | 1 | Host bridge grant, active high |
| cfg_rdata | output | 32 | Control word read-back |

## Verification
The assertions assume that `strap_en` is stable for the whole reset pulse. They also assume that FRAME# and IRDY# follow legal bus sequencing, with IRDY# released one cycle after FRAME# at the end of each transaction. The stimulus drives FRAME# and IRDY# only through a task that produces either a complete single-phase transaction or an address-only pulse, so the bus is always idle again before the next request pattern is applied. Each request pattern is held for eight cycles so that the removal, gap and new-grant stages settle before any check samples the grants.

// File: rtl/pcarb_pkg.sv
package pcarb_pkg;

    // control word layout (behavioural: software writes these positions)
    localparam int CFG_W    = 32;
    localparam int LIM_LSB  = 28;
    localparam int LIM_W    = 4;
    localparam int PARK_BIT = 27;

endpackage

// File: rtl/pcarb_prio_tree.sv
module pcarb_prio_tree #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    localparam int LV     = $clog2(N);
    localparam int LEAVES = 1 << LV;

    logic [LEAVES-1:0] pad;
    logic              nv [1:2*LEAVES-1];
    logic [IW-1:0]     ni [1:2*LEAVES-1];

    // heap-ordered tree of two-input nodes; the left input always wins
    always_comb begin
        pad = LEAVES'(req);
        for (int i = 0; i < LEAVES; i++) begin
            nv[LEAVES+i] = pad[i];
            ni[LEAVES+i] = IW'(i);
        end
        for (int k = LEAVES-1; k >= 1; k--) begin
            nv[k] = nv[2*k] | nv[2*k+1];
            ni[k] = nv[2*k] ? ni[2*k] : ni[2*k+1];
        end
        any = nv[1];
        idx = ni[1];
    end

endmodule

// File: rtl/pcarb_cfg_reg.sv
module pcarb_cfg_reg
    import pcarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [LIM_W-1:0] lim,
    output logic             park_last
);
    logic [LIM_W-1:0] lim_d, lim_q;
    logic             park_d, park_q;
    logic             unused_low;

    assign unused_low = ^wdata[PARK_BIT-1:0];

    always_comb begin
        lim_d  = lim_q;
        park_d = park_q;
        if (wr) begin
            lim_d  = wdata[LIM_LSB +: LIM_W];
            park_d = wdata[PARK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q  <= '0;
            park_q <= 1'b0;
        end else begin
            lim_q  <= lim_d;
            park_q <= park_d;
        end
    end

    always_comb begin
        rdata                    = '0;
        rdata[LIM_LSB +: LIM_W]  = lim_q;
        rdata[PARK_BIT]          = park_q;
    end

    assign lim       = lim_q;
    assign park_last = park_q;

endmodule

// File: rtl/pcarb_xact_mon.sv
module pcarb_xact_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic bus_idle,
    output logic xact_done
);
    typedef struct packed {
        logic f1;
        logic i1;
        logic f2;
        logic i2;
    } mon_t;

    mon_t d, q;

    always_comb begin
        d    = q;
        d.f1 = frame_n;
        d.i1 = irdy_n;
        d.f2 = q.f1;
        d.i2 = q.i1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{f1: 1'b1, i1: 1'b1, f2: 1'b1, i2: 1'b1};
        else        q <= d;
    end

    // last data phase (FRAME# high, IRDY# low) followed by IRDY# release
    assign xact_done = q.f2 & ~q.i2 & q.i1;
    assign bus_idle  = q.f1 & q.i1;

endmodule

// File: rtl/pci_prio_arbiter.sv
module pci_prio_arbiter
    import pcarb_pkg::*;
#(
    parameter int N_REQ = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_en,
    input  logic [N_REQ-1:0] req_n,
    input  logic             host_req,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [N_REQ-1:0] gnt_n,
    output logic             host_gnt,
    output logic [CFG_W-1:0] cfg_rdata
);
    localparam int NA   = N_REQ + 1;
    localparam int AW   = $clog2(NA);
    localparam int HOST = N_REQ;

    typedef struct packed {
        logic             granted;
        logic [AW-1:0]    owner;
        logic [AW-1:0]    last;
        logic [LIM_W-1:0] cnt;
        logic [NA-1:0]    barred;
        logic [NA-1:0]    req;
        logic [NA-1:0]    gnt;
    } arb_t;

    arb_t d, q;
    logic en_q;

    logic [LIM_W-1:0] lim;
    logic             park_last;
    logic             bus_idle, xact_done;
    logic             m_any, u_any;
    logic [AW-1:0]    m_idx, u_idx;
    logic [AW-1:0]    park_tgt, tgt;
    logic             lower_pend, lim_hit, drop;

    pcarb_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .lim       (lim),
        .park_last (park_last)
    );

    pcarb_xact_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .bus_idle  (bus_idle),
        .xact_done (xact_done)
    );

    // winner among agents not held back by the limit
    pcarb_prio_tree #(.N(NA), .IW(AW)) u_tree_masked (
        .req (q.req & ~q.barred),
        .any (m_any),
        .idx (m_idx)
    );

    // winner among all requesters (fallback when only a held-back agent asks)
    pcarb_prio_tree #(.N(NA), .IW(AW)) u_tree_all (
        .req (q.req),
        .any (u_any),
        .idx (u_idx)
    );

    // enable strap captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= strap_en;
    end

    always_comb begin
        lower_pend = 1'b0;
        for (int i = 0; i < NA; i++) begin
            if (i > int'(q.owner)) lower_pend = lower_pend | q.req[i];
        end
    end

    always_comb begin
        park_tgt = park_last ? q.last : AW'(HOST);
        lim_hit  = (lim != '0) && (q.cnt >= lim) && lower_pend;
        drop     = !q.req[q.owner] && ((|q.req) || (q.owner != park_tgt));
        tgt      = m_any ? m_idx : (u_any ? u_idx : park_tgt);

        d     = q;
        d.req = {host_req, ~req_n};

        if (!en_q) begin
            d.granted = 1'b0;
            d.gnt     = '0;
        end else if (q.granted) begin
            if (xact_done && (q.cnt != '1)) d.cnt = q.cnt + 1'b1;
            if (lim_hit || drop) begin
                d.granted = 1'b0;
                d.gnt     = '0;
                if (lim_hit) d.barred = NA'(1) << q.owner;
            end
        end else if (bus_idle) begin
            d.granted = 1'b1;
            d.owner   = tgt;
            d.last    = tgt;
            d.gnt     = NA'(1) << tgt;
            if (tgt != q.last)    d.cnt    = '0;
            if (!q.barred[tgt])   d.barred = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.owner   <= AW'(HOST);
            q.last    <= AW'(HOST);
        end else begin
            q <= d;
        end
    end

    assign gnt_n    = ~q.gnt[N_REQ-1:0];
    assign host_gnt = q.gnt[HOST];

    // R1
    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.gnt));

    // R9
    a_r9_no_grant_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (q.gnt == '0));

    // R10
    a_r10_gap_between_agents: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.gnt) |=> ((q.gnt == $past(q.gnt)) || (q.gnt == '0)));

    // R10
    a_r10_grant_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.granted) |-> $past(bus_idle));

endmodule

// File: tb/pci_prio_arbiter_tb_top.sv
module pci_prio_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_en = 1'b1;
    logic [5:0]  req_n = '1;
    logic        host_req = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  gnt_n;
    logic        host_gnt;
    logic [31:0] cfg_rdata;

    always #5 clk = ~clk;

    pci_prio_arbiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_en  (strap_en),
        .req_n     (req_n),
        .host_req  (host_req),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .gnt_n     (gnt_n),
        .host_gnt  (host_gnt),
        .cfg_rdata (cfg_rdata)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    int   mon_viol = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    logic [6:0] prev_g = '0;
    logic [6:0] cur_g;
    int   m_owner, m_last;

    function automatic int enc(logic [6:0] g);
        if ($countones(g) > 1) return 8;
        for (int i = 0; i < 7; i++) if (g[i]) return i;
        return 7;
    endfunction

    function automatic int lowest(logic [6:0] v);
        for (int i = 0; i < 7; i++) if (v[i]) return i;
        return 7;
    endfunction

    // expected steady owner from the requirements (R2, R3, R6, R7)
    function automatic int model(int owner, int last, logic [6:0] v, bit pl);
        if (owner < 7 && v[owner]) return owner;
        if (v != 0) return lowest(v);
        return pl ? last : 6;
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_gnt(int exp, string rq);
        int a;
        a = enc({host_gnt, ~gnt_n});
        chk(a == exp, rq, "grant owner", a, exp);
    endtask

    task automatic apply(logic [6:0] v);
        @(negedge clk);
        req_n    = ~v[5:0];
        host_req = v[6];
        repeat (8) @(negedge clk);
    endtask

    task automatic write_cfg(int lim, bit pl);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {lim[3:0], pl, 27'h5a5a5a5};
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic full_txn();
        @(negedge clk); frame_n = 1'b0; irdy_n = 1'b0;
        @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0;
        @(negedge clk); irdy_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic addr_only();
        @(negedge clk); frame_n = 1'b0;
        @(negedge clk); frame_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(bit s);
        @(negedge clk);
        rst_n = 1'b0; strap_en = s;
        req_n = '1; host_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            cur_g = {host_gnt, ~gnt_n};
            if ($countones(cur_g) > 1) mon_viol++;
            if (prev_g != 0 && cur_g != 0 && cur_g != prev_g) mon_viol++;
            prev_g = cur_g;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        int s;
        int e;
        logic [6:0] v;
        bit pl;
        s = $urandom(32'd4711);

        // reset state (R8, R1)
        do_reset(1'b1);
        chk(cfg_rdata == 32'h0, "R8", "reset word", cfg_rdata, 0);
        chk_gnt(7, "R1");
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        mon_on = 1'b1;
        chk_gnt(6, "R6");

        // R8 read-back of writable and reserved bits
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_rdata == 32'hF800_0000, "R8", "all-ones write", cfg_rdata, 32'hF800_0000);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'h0000_0000;
        @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_rdata == 32'h0, "R8", "zero write", cfg_rdata, 0);

        // random request patterns against the model (R2, R3, R6, R7)
        m_owner = 6; m_last = 6; pl = 1'b0;
        for (int p = 0; p < 48; p++) begin
            if (p % 12 == 0) begin
                pl = 1'($urandom % 2);
                write_cfg(0, pl);
            end
            v = 7'($urandom & $urandom);
            apply(v);
            e = model(m_owner, m_last, v, pl);
            m_owner = e; m_last = e;
            chk_gnt(e, "R2");
        end

        // directed priority (R2) and no preemption (R3)
        write_cfg(0, 1'b0);
        apply(7'b0000000);
        apply(7'b0101100);
        chk_gnt(2, "R2");
        apply(7'b1100000);
        chk_gnt(5, "R2");
        apply(7'b0100001);
        chk_gnt(5, "R3");

        // limit of two with a lower requester waiting (R4), then none lower (R5)
        write_cfg(2, 1'b0);
        apply(7'b0000000);
        apply(7'b0001010);
        chk_gnt(1, "R4");
        full_txn();
        chk_gnt(1, "R4");
        full_txn();
        chk_gnt(3, "R4");
        full_txn(); full_txn(); full_txn();
        chk_gnt(3, "R5");

        // address-only pulse is not a transaction (R11)
        write_cfg(1, 1'b0);
        apply(7'b0000000);
        apply(7'b0001010);
        chk_gnt(1, "R11");
        addr_only();
        chk_gnt(1, "R11");
        full_txn();
        chk_gnt(3, "R11");

        // field 0 disables the limit (R5)
        write_cfg(0, 1'b0);
        apply(7'b0000000);
        apply(7'b0001010);
        full_txn(); full_txn(); full_txn(); full_txn();
        chk_gnt(1, "R5");

        // parking modes (R7, R6)
        write_cfg(0, 1'b1);
        apply(7'b0010000);
        chk_gnt(4, "R7");
        apply(7'b0000000);
        chk_gnt(4, "R7");
        write_cfg(0, 1'b0);
        apply(7'b0000000);
        chk_gnt(6, "R6");

        // continuous grant monitor (R1, R10)
        chk(mon_viol == 0, "R10", "grant overlap or switch without gap", mon_viol, 0);

        // strap low: no grant at all (R9)
        mon_on = 1'b0;
        do_reset(1'b0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk_gnt(7, "R9");
        apply(7'b0000100);
        chk_gnt(7, "R9");
        apply(7'b1111111);
        chk_gnt(7, "R9");
        full_txn();
        chk_gnt(7, "R9");

        summary();
    end

endmodule